// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Overflow Trap

This block is a purely combinational arithmetic and logic unit. It is assembled from a chain of identical one-bit slices. Each slice forms a bitwise AND, a bitwise OR and a full-adder sum for its bit position, and a decoded operation code picks one of them. A ripple carry links each slice to the next one up.

Subtraction uses the same adder chain. Each slice inverts its `b` bit, and the carry into bit 0 is forced high, so the block computes `a + ~b + 1`. The flag logic reports the carry out of the top bit, the signed overflow and an all-zero result. When a signed add or subtract overflows, the block raises an exception request. A qualifier input marks the operation as unsigned, and in that case no request is raised.

A pipeline stage places the block between its operand registers and its result register. It reads `op_i`, `unsigned_i` and the operands in the same cycle that it drives every output.

Top module: `alu_bitslice_top`

## Requirements
- R1: With `op_i` = 3'b000, `res_o` equals `a_i & b_i`.
- R2: With `op_i` = 3'b001, `res_o` equals `a_i | b_i`.
- R3: With `op_i` = 3'b010, `res_o` equals `(a_i + b_i) mod 2^WIDTH`, and `carry_o` is the carry out of the top bit.
- R4: With `op_i` = 3'b110, `res_o` equals `(a_i - b_i) mod 2^WIDTH`, and `carry_o` is the top carry of `a_i + ~b_i + 1`. This carry is 1 exactly when `a_i >= b_i` as unsigned numbers.
- R5: On add, `ovf_o` is 1 exactly when both operands have the same sign bit and the sign bit of `res_o` differs from it. Operands with different signs never overflow.
- R6: On subtract, `ovf_o` is 1 exactly when the operand signs differ and the sign bit of `res_o` differs from the sign of `a_i`.
- R7: `trap_o` is 1 exactly when `ovf_o` is 1, the operation is add or subtract, and `unsigned_i` is 0.
- R8: `unsigned_i` has no effect on `res_o`, `carry_o`, `ovf_o` or `zero_o`. The raw overflow is still reported while the trap is suppressed.
- R9: For AND and OR, `carry_o`, `ovf_o` and `trap_o` are 0.
- R10: Any other `op_i` code gives `res_o` = 0 and drives `carry_o`, `ovf_o` and `trap_o` to 0.
- R11: `zero_o` is 1 exactly when every bit of `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation: 000 AND, 001 OR, 010 ADD, 110 SUB; any other code gives a zero result |
| unsigned_i | input | 1 | Marks add or subtract as unsigned, which suppresses the trap |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| res_o | output | WIDTH | Result |
| carry_o | output | 1 | Carry out of the top slice (add or subtract only) |
| ovf_o | output | 1 | Signed overflow (add or subtract only) |
| zero_o | output | 1 | Result is all zeros |
| trap_o | output | 1 | Exception request on signed overflow |

## Verification
Every output is a pure function of the present inputs, so each result is due in the same cycle as its stimulus, with no register in the path. The bench applies each new vector just after a rising clock edge. It samples all five outputs at the following falling edge, which leaves half a clock period for the ripple chain to settle. No check reads a value across a clock edge.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_ZERO = 2'd3
    } slice_sel_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic       binv_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       cout_o
);
    logic b_eff;
    logic sum;

    always_comb begin
        b_eff  = b_i ^ binv_i;
        sum    = a_i ^ b_eff ^ cin_i;
        cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
        unique case (sel_i)
            SEL_AND: res_o = a_i & b_i;
            SEL_OR:  res_o = a_i | b_i;
            SEL_SUM: res_o = sum;
            default: res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [2:0] op_i,
    output slice_sel_e sel_o,
    output logic       binv_o,
    output logic       arith_o
);
    always_comb begin
        sel_o   = SEL_ZERO;
        binv_o  = 1'b0;
        arith_o = 1'b0;
        unique case (op_i)
            OP_AND: sel_o = SEL_AND;
            OP_OR:  sel_o = SEL_OR;
            OP_ADD: begin
                sel_o   = SEL_SUM;
                arith_o = 1'b1;
            end
            OP_SUB: begin
                sel_o   = SEL_SUM;
                binv_o  = 1'b1;
                arith_o = 1'b1;
            end
            default: sel_o = SEL_ZERO;
        endcase
    end
endmodule

// File: rtl/alu_chain.sv
module alu_chain
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             binv_i,
    input  slice_sel_e       sel_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_msb_in_o,
    output logic             c_msb_out_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] carry;

    // The carry into bit 0 supplies the +1 of the two's-complement negate.
    assign carry[0] = binv_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .a_i   (a_i[i]),
            .b_i   (b_i[i]),
            .cin_i (carry[i]),
            .binv_i(binv_i),
            .sel_i (sel_i),
            .res_o (res_o[i]),
            .cout_o(carry[i+1])
        );
    end

    assign c_msb_in_o  = carry[MSB];
    assign c_msb_out_o = carry[WIDTH];
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] res_i,
    input  logic             arith_i,
    input  logic             unsigned_i,
    input  logic             c_msb_in_i,
    input  logic             c_msb_out_i,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o,
    output logic             trap_o
);
    always_comb begin
        carry_o = arith_i & c_msb_out_i;
        // A signed result leaves its range when the carry into the sign bit differs from the carry out of it.
        ovf_o   = arith_i & (c_msb_in_i ^ c_msb_out_i);
        trap_o  = ovf_o & ~unsigned_i;
        zero_o  = ~|res_i;
    end
endmodule

// File: rtl/alu_bitslice_top.sv
module alu_bitslice_top
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2:0]       op_i,
    input  logic             unsigned_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             zero_o,
    output logic             trap_o
);
    slice_sel_e sel;
    logic       binv;
    logic       arith;
    logic       c_msb_in;
    logic       c_msb_out;

    alu_decode u_decode (
        .op_i   (op_i),
        .sel_o  (sel),
        .binv_o (binv),
        .arith_o(arith)
    );

    alu_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i        (a_i),
        .b_i        (b_i),
        .binv_i     (binv),
        .sel_i      (sel),
        .res_o      (res_o),
        .c_msb_in_o (c_msb_in),
        .c_msb_out_o(c_msb_out)
    );

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i      (res_o),
        .arith_i    (arith),
        .unsigned_i (unsigned_i),
        .c_msb_in_i (c_msb_in),
        .c_msb_out_i(c_msb_out),
        .carry_o    (carry_o),
        .ovf_o      (ovf_o),
        .zero_o     (zero_o),
        .trap_o     (trap_o)
    );
endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
    parameter int WIDTH = 32
) (
    input logic [2:0]       op_i,
    input logic             unsigned_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] res_o,
    input logic             carry_o,
    input logic             ovf_o,
    input logic             zero_o,
    input logic             trap_o
);
    localparam int MSB = WIDTH - 1;

    logic is_add;
    logic is_logic;
    logic is_valid;

    always_comb begin
        is_add   = (op_i == 3'b010);
        is_logic = (op_i == 3'b000) || (op_i == 3'b001);
        is_valid = is_logic || is_add || (op_i == 3'b110);

        // R11
        zero_flag_chk: assert (zero_o == (res_o == '0));
        // R7
        trap_gate_chk: assert (!unsigned_i || !trap_o);
        // R7
        trap_needs_ovf_chk: assert (!trap_o || ovf_o);
        // R5
        no_overflow_chk: assert (!(is_add && (a_i[MSB] != b_i[MSB])) || !ovf_o);
        // R9
        logic_flags_chk: assert (!is_logic || (!carry_o && !ovf_o && !trap_o));
        // R10
        bad_op_chk: assert (is_valid || (res_o == '0 && !carry_o && !ovf_o && !trap_o));
    end
endmodule

bind alu_bitslice_top alu_bitslice_chk #(.WIDTH(WIDTH)) u_chk (
    .op_i      (op_i),
    .unsigned_i(unsigned_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .res_o     (res_o),
    .carry_o   (carry_o),
    .ovf_o     (ovf_o),
    .zero_o    (zero_o),
    .trap_o    (trap_o)
);

// File: tb/alu_bitslice_top_bench.sv
module alu_bitslice_top_bench;
    localparam int W = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [2:0]   op;
    logic         uns;
    logic [W-1:0] a, b;
    logic [W-1:0] res;
    logic         carry, ovf, zero, trap;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    alu_bitslice_top #(.WIDTH(W)) u_alu_bitslice_top (
        .op_i(op), .unsigned_i(uns), .a_i(a), .b_i(b),
        .res_o(res), .carry_o(carry), .ovf_o(ovf), .zero_o(zero), .trap_o(trap)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h uns=%b act=%h exp=%h", req, op, a, b, uns, act, exp);
        end
    endtask

    // Reference model, written from the requirements.
    function automatic logic [W+2:0] model(input logic [2:0] o, input logic u,
                                           input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic c, v, t;
        r = '0; c = 1'b0; v = 1'b0;
        case (o)
            3'b000: r = x & y;
            3'b001: r = x | y;
            3'b010: begin
                s = {1'b0, x} + {1'b0, y};
                r = s[W-1:0]; c = s[W];
                v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
            end
            3'b110: begin
                s = {1'b0, x} + {1'b0, ~y} + 1;
                r = s[W-1:0]; c = s[W];
                v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
            end
            default: r = '0;
        endcase
        t = v && !u;
        return {t, v, c, r};
    endfunction

    task automatic apply(input logic [2:0] o, input logic u,
                         input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W+2:0] e;
        string rr;
        @(posedge clk);
        op = o; uns = u; a = x; b = y;
        @(negedge clk);
        e = model(o, u, x, y);
        case (o)
            3'b000:  rr = "R1";
            3'b001:  rr = "R2";
            3'b010:  rr = "R3";
            3'b110:  rr = "R4";
            default: rr = "R10";
        endcase
        chk({rr, " result"}, res, e[W-1:0]);
        chk((o == 3'b110) ? "R4 carry" : ((o == 3'b010) ? "R3 carry" : "R9/R10 carry"),
            {31'd0, carry}, {31'd0, e[W]});
        chk((o == 3'b110) ? "R6 ovf" : ((o == 3'b010) ? "R5 ovf" : "R9/R10 ovf"),
            {31'd0, ovf}, {31'd0, e[W+1]});
        chk("R7 trap", {31'd0, trap}, {31'd0, e[W+2]});
        chk("R11 zero", {31'd0, zero}, {31'd0, (e[W-1:0] == '0)});
    endtask

    // Run each vector once as signed and once as unsigned: every output except the trap must match.
    task automatic pair_r8(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W+2:0] s0, s1;
        apply(o, 1'b0, x, y);
        s0 = {trap, ovf, carry, res};
        apply(o, 1'b1, x, y);
        s1 = {trap, ovf, carry, res};
        chk("R8 uns-invariant", s1[W-1:0], s0[W-1:0]);
        chk("R8 uns-invariant flags", {30'd0, s1[W+1:W]}, {30'd0, s0[W+1:W]});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] ops [8];
        ops = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b011, 3'b100, 3'b101, 3'b111};
        op = 3'b000; uns = 1'b0; a = '0; b = '0;
        @(negedge clk);
        // R11: an AND of zeros right after power-up
        chk("R11 initial zero", {31'd0, zero}, 32'd1);

        // R5 corner: overflow from most-positive plus one
        apply(3'b010, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001);
        // R6 corners
        apply(3'b110, 1'b0, 32'h8000_0000, 32'h0000_0001);
        apply(3'b110, 1'b0, 32'h0000_0000, 32'h8000_0000);
        // R8 unsigned variants of the same corners
        pair_r8(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
        pair_r8(3'b110, 32'h0000_0000, 32'h8000_0000);
        // R3 carry without overflow (mixed signs)
        apply(3'b010, 1'b0, 32'h7000_0000, 32'hA000_0000);
        apply(3'b010, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001);
        // R4 equal operands: zero result, no borrow
        apply(3'b110, 1'b0, 32'h1234_5678, 32'h1234_5678);
        // R5 two negatives overflowing
        apply(3'b010, 1'b0, 32'h8000_0000, 32'h8000_0000);
        // R10 invalid codes with all-ones operands
        for (int k = 4; k < 8; k++) apply(ops[k], 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R9 logic ops never flag
        apply(3'b001, 1'b0, 32'h0, 32'h0);
        apply(3'b000, 1'b0, 32'hFFFF_FFFF, 32'h8000_0001);

        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] x, y;
            logic [2:0]   o;
            x = $urandom;
            y = $urandom;
            o = ops[$urandom % 8];
            if (($urandom % 4) == 0) y = {~x[W-1], y[W-2:0]};
            if (($urandom % 4) == 1) x = {x[W-1], {(W-1){~x[W-1]}}};
            if (($urandom % 2) == 0) pair_r8(o, x, y);
            else apply(o, $urandom % 2, x, y);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule